// File: doc/BRIEF.md
# Double-Pass Depuncture Sequencer

This block sits in front of an ordinary zero-start block decoder for a rate 2/3 punctured, tail-biting convolutional code. It gathers one received block of 24 coded soft symbols into local storage. Once the block is complete, it plays the block out twice in a row. On the way out it puts a neutral zero soft value into every punctured position. Each pass therefore presents 16 symbol pairs, and the two passes together present 32 pairs at one pair per clock.

Only the first pair of the first pass carries the block-start flag. The decoder then treats both passes as a single 32-step block. The first pass lets its path metrics settle on the true start state, so only the second half of its output need be kept. Storage is organised as a ring of block buffers, two by default. A new block can be written while the previous one is being replayed, and the input is held off only when every buffer is occupied.

A block that is cut short by a new block-start is reported on a one-cycle error pulse and thrown away. Symbols that arrive outside a block are ignored.

Top module: `dpsq_top`

## Requirements
- R1: While reset is held, and in the cycle after it, `out_valid`, `out_start` and `blk_err` are 0 and `in_ready` is 1.
- R2: A block is complete once 24 symbols have been accepted, the first with `in_start`. If the replay side is idle, the first output pair appears two clock edges after the edge that accepts the 24th symbol. Exactly 32 consecutive valid pairs follow. When a later block is already stored, the next replay starts after one idle cycle.
- R3: Stored symbols s[0..23] are numbered in arrival order. Pair p of a pass (p = 0..15, g = p/2) is (x,y) = (s[3g], s[3g+1]) when p is even and (0, s[3g+2]) when p is odd. Zero is the erasure value.
- R4: Pairs 16..31 of a replay repeat pairs 0..15 exactly, from the same stored block.
- R5: `out_start` is 1 only with the first pair of the first pass, and never in any other cycle.
- R6: `in_ready` is 0 exactly when every buffer holds a block that is waiting or being replayed. A block can be written during the replay of an earlier one, and blocks are replayed in arrival order.
- R7: An accepted `in_start` while a block is partly received gives a one-cycle `blk_err` pulse in the next cycle. The partial block produces no output, and the symbol carrying `in_start` becomes symbol 0 of a new block.
- R8: Valid symbols without `in_start` while no block is in progress are ignored: they produce no output and no error.
- R9: A symbol offered while `in_ready` is 0 is not taken. Its value and its start flag have no effect on stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input soft symbol is valid |
| in_start | input | 1 | Input symbol is the first of a block |
| in_sym | input | SW | Input soft symbol, two's complement |
| in_ready | output | 1 | Block accepts a symbol this cycle |
| out_valid | output | 1 | Output pair is valid |
| out_start | output | 1 | First pair of a 32-step decode block |
| out_x | output | SW | First soft value of the pair (zero when erased) |
| out_y | output | SW | Second soft value of the pair |
| blk_err | output | 1 | One-cycle pulse: truncated block dropped |

## Verification
A write pointer off by one shows up in the first replay as shifted or swapped pair values, within 2 to 33 cycles of the block's last symbol. A pass or pair counter that goes wrong changes the length of the `out_valid` run, or puts `out_start` in the wrong place, in the cycle the replay starts or ends. An occupancy flag that is set or cleared wrongly shows at `in_ready` in the very next cycle. It also shows later as a replay of stale or overwritten data. The bench keeps its own model of the block queue and compares every output against it on every clock, so each of these faults is caught in the first cycle it reaches a port.

// File: rtl/dpsq_pkg.sv
// Package: shared helpers for the double-pass depuncture sequencer.
// Assumes rate 2/3 puncturing. Every two trellis steps carry three stored
// symbols, in the order x(even), y(even), y(odd).
package dpsq_pkg;

    // Returns the stored-symbol slot feeding one half of an output pair.
    function automatic int unsigned slot_of(input int unsigned pair, input bit second);
        int unsigned base;
        base = (pair / 2) * 3;
        if (!second) return base;
        return ((pair % 2) == 0) ? base + 1 : base + 2;
    endfunction

    // Returns 1 when the x half of this pair was punctured away.
    function automatic bit is_erased(input int unsigned pair);
        return (pair % 2) == 1;
    endfunction

endpackage

// File: rtl/dpsq_store.sv
// Module: block storage ring with one write port and two combinational read
// ports. Assumes the writer and the reader never address the same buffer at
// the same time; the occupancy flags in the write controller guarantee this.
module dpsq_store #(
    parameter int SW   = 4,
    parameter int BLK  = 24,
    parameter int NBUF = 2,
    localparam int CW  = $clog2(BLK),
    localparam int BW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [BW-1:0] wbuf,
    input  logic [CW-1:0] waddr,
    input  logic [SW-1:0] wdata,
    input  logic [BW-1:0] rbuf,
    input  logic [CW-1:0] raddr_a,
    input  logic [CW-1:0] raddr_b,
    output logic [SW-1:0] rdata_a,
    output logic [SW-1:0] rdata_b
);
    localparam int DEPTH = NBUF * BLK;
    localparam int AW    = $clog2(DEPTH);

    logic [SW-1:0] mem [DEPTH];
    logic [AW-1:0] widx, ia, ib;

    assign widx = AW'(wbuf) * AW'(BLK) + AW'(waddr);
    assign ia   = AW'(rbuf) * AW'(BLK) + AW'(raddr_a);
    assign ib   = AW'(rbuf) * AW'(BLK) + AW'(raddr_b);

    // Store one accepted symbol.
    always_ff @(posedge clk) begin
        if (we) mem[widx] <= wdata;
    end

    // Fetch both halves of the current pair.
    always_comb begin
        rdata_a = mem[ia];
        rdata_b = mem[ib];
    end
endmodule

// File: rtl/dpsq_wr_ctrl.sv
// Module: write controller. It counts the symbols of the block in progress,
// picks the buffer to fill, owns the occupancy flag of every buffer and
// reports truncated blocks. Assumes that rel marks the last replay cycle of
// buffer rbuf.
module dpsq_wr_ctrl #(
    parameter int SW   = 4,
    parameter int BLK  = 24,
    parameter int NBUF = 2,
    localparam int CW  = $clog2(BLK),
    localparam int BW  = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic            in_start,
    input  logic [SW-1:0]   in_sym,
    input  logic            rel,
    input  logic [BW-1:0]   rbuf,
    output logic            in_ready,
    output logic            we,
    output logic [BW-1:0]   wbuf,
    output logic [CW-1:0]   waddr,
    output logic [SW-1:0]   wdata,
    output logic [NBUF-1:0] full,
    output logic            blk_err
);
    logic [CW-1:0]   wcnt_q;
    logic [BW-1:0]   wbuf_q;
    logic [NBUF-1:0] full_q;
    logic            err_q;
    logic            accept, take, fill_done;

    assign in_ready  = !full_q[wbuf_q];
    assign accept    = in_valid && in_ready;
    assign take      = accept && (in_start || (wcnt_q != '0));
    assign waddr     = in_start ? '0 : wcnt_q;
    assign fill_done = take && (waddr == CW'(BLK - 1));
    assign we        = take;
    assign wbuf      = wbuf_q;
    assign wdata     = in_sym;
    assign full      = full_q;
    assign blk_err   = err_q;

    // Track the position inside the block being received; zero means idle.
    always_ff @(posedge clk) begin
        if (!rst_n)        wcnt_q <= '0;
        else if (fill_done) wcnt_q <= '0;
        else if (take)     wcnt_q <= waddr + 1'b1;
    end

    // Move to the next buffer of the ring after a block is complete.
    always_ff @(posedge clk) begin
        if (!rst_n)         wbuf_q <= '0;
        else if (fill_done) wbuf_q <= (wbuf_q == BW'(NBUF - 1)) ? '0 : wbuf_q + 1'b1;
    end

    // Mark buffers full on completion and free them when their replay ends.
    always_ff @(posedge clk) begin
        if (!rst_n) full_q <= '0;
        else begin
            for (int b = 0; b < NBUF; b++) begin
                if (fill_done && (wbuf_q == BW'(b)))  full_q[b] <= 1'b1;
                else if (rel && (rbuf == BW'(b)))     full_q[b] <= 1'b0;
            end
        end
    end

    // Flag a block-start that cuts a partial block short.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= accept && in_start && (wcnt_q != '0);
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> $stable(wcnt_q));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_err |-> $past(in_valid && in_start));

    // R6
    ready_low_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> (&full_q));
endmodule

// File: rtl/dpsq_rd_seq.sv
// Module: replay sequencer and depuncturer. It waits for the oldest full
// buffer, reads it out twice as 16 pairs per pass, zeroes the punctured x
// halves, registers the pair and frees the buffer in its final cycle.
// Assumes NPAIRS is even.
module dpsq_rd_seq #(
    parameter int SW     = 4,
    parameter int NPAIRS = 16,
    parameter int NBUF   = 2,
    localparam int BLK   = NPAIRS * 3 / 2,
    localparam int CW    = $clog2(BLK),
    localparam int PW    = $clog2(NPAIRS),
    localparam int BW    = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBUF-1:0] full,
    input  logic [SW-1:0]   rdata_a,
    input  logic [SW-1:0]   rdata_b,
    output logic [BW-1:0]   rbuf,
    output logic [CW-1:0]   raddr_a,
    output logic [CW-1:0]   raddr_b,
    output logic            rel,
    output logic            out_valid,
    output logic            out_start,
    output logic [SW-1:0]   out_x,
    output logic [SW-1:0]   out_y
);
    import dpsq_pkg::*;

    localparam logic [PW-1:0] LAST = PW'(NPAIRS - 1);

    logic          act_q, pass_q;
    logic [PW-1:0] pair_q;
    logic [BW-1:0] rbuf_q;
    logic          vld_q, st_q;
    logic [SW-1:0] x_q, y_q;
    logic          erased, pass_end;

    assign erased   = is_erased(32'(pair_q));
    assign raddr_a  = CW'(slot_of(32'(pair_q), 1'b0));
    assign raddr_b  = CW'(slot_of(32'(pair_q), 1'b1));
    assign pass_end = act_q && (pair_q == LAST);
    assign rel      = pass_end && pass_q;
    assign rbuf     = rbuf_q;

    // Step through both passes of the oldest full buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            pass_q <= 1'b0;
            pair_q <= '0;
            rbuf_q <= '0;
        end else if (act_q) begin
            pair_q <= pass_end ? '0 : pair_q + 1'b1;
            if (pass_end) begin
                pass_q <= !pass_q;
                if (pass_q) begin
                    act_q  <= 1'b0;
                    rbuf_q <= (rbuf_q == BW'(NBUF - 1)) ? '0 : rbuf_q + 1'b1;
                end
            end
        end else if (full[rbuf_q]) begin
            act_q <= 1'b1;
        end
    end

    // Register the depunctured pair and its flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            st_q  <= 1'b0;
            x_q   <= '0;
            y_q   <= '0;
        end else begin
            vld_q <= act_q;
            st_q  <= act_q && !pass_q && (pair_q == '0);
            x_q   <= (act_q && !erased) ? rdata_a : '0;
            y_q   <= act_q ? rdata_b : '0;
        end
    end

    assign out_valid = vld_q;
    assign out_start = st_q;
    assign out_x     = x_q;
    assign out_y     = y_q;

    // R3
    erase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && pair_q[0]) |=> (out_x == '0));

    // R5
    start_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |-> out_valid);

    // R4
    second_pass_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q && pass_q) |-> full[rbuf_q]);
endmodule

// File: rtl/dpsq_top.sv
// Module: double-pass depuncture sequencer top. It joins the write
// controller, the buffer ring and the replay sequencer. Assumes the
// downstream decoder takes one pair in every cycle that out_valid is high.
module dpsq_top #(
    parameter int SW     = 4,
    parameter int NPAIRS = 16,
    parameter int NBUF   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_start,
    input  logic [SW-1:0] in_sym,
    output logic          in_ready,
    output logic          out_valid,
    output logic          out_start,
    output logic [SW-1:0] out_x,
    output logic [SW-1:0] out_y,
    output logic          blk_err
);
    localparam int BLK = NPAIRS * 3 / 2;
    localparam int CW  = $clog2(BLK);
    localparam int BW  = (NBUF > 1) ? $clog2(NBUF) : 1;

    logic            we, rel;
    logic [BW-1:0]   wbuf, rbuf;
    logic [CW-1:0]   waddr, raddr_a, raddr_b;
    logic [SW-1:0]   wdata, rdata_a, rdata_b;
    logic [NBUF-1:0] full;

    dpsq_wr_ctrl #(.SW(SW), .BLK(BLK), .NBUF(NBUF)) u_wr (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_sym(in_sym), .rel(rel), .rbuf(rbuf), .in_ready(in_ready),
        .we(we), .wbuf(wbuf), .waddr(waddr), .wdata(wdata), .full(full),
        .blk_err(blk_err)
    );

    dpsq_store #(.SW(SW), .BLK(BLK), .NBUF(NBUF)) u_store (
        .clk(clk), .we(we), .wbuf(wbuf), .waddr(waddr), .wdata(wdata),
        .rbuf(rbuf), .raddr_a(raddr_a), .raddr_b(raddr_b),
        .rdata_a(rdata_a), .rdata_b(rdata_b)
    );

    dpsq_rd_seq #(.SW(SW), .NPAIRS(NPAIRS), .NBUF(NBUF)) u_rd (
        .clk(clk), .rst_n(rst_n), .full(full), .rdata_a(rdata_a),
        .rdata_b(rdata_b), .rbuf(rbuf), .raddr_a(raddr_a), .raddr_b(raddr_b),
        .rel(rel), .out_valid(out_valid), .out_start(out_start),
        .out_x(out_x), .out_y(out_y)
    );

    // R2
    run_opens_with_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_start);
endmodule

// File: tb/dpsq_top_bench.sv
`timescale 1ns/1ps
// Bench: behavioural queue model of the sequencer, compared on every clock.
module dpsq_top_bench;
    localparam int SW = 4;
    localparam int NP = 16;
    localparam int BLK = 24;
    localparam int NB = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_start = 1'b0;
    logic [SW-1:0] in_sym = '0;
    logic in_ready, out_valid, out_start, blk_err;
    logic [SW-1:0] out_x, out_y;

    int checks = 0, errors = 0, cyc = 0;
    bit cmp_en = 0, stall_ph = 0, stall_seen = 0;
    int ov_cnt = 0, err_seen = 0;

    dpsq_top #(.SW(SW), .NPAIRS(NP), .NBUF(NB)) u_dpsq_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_start(in_start),
        .in_sym(in_sym), .in_ready(in_ready), .out_valid(out_valid),
        .out_start(out_start), .out_x(out_x), .out_y(out_y), .blk_err(blk_err)
    );

    always #4 clk = ~clk;

    // Model state: block in progress, queue of stored blocks, replay position.
    int m_cnt = 0;
    logic [BLK*SW-1:0] m_cur = '0;
    logic [BLK*SW-1:0] m_q[$];
    bit m_act = 0;
    int m_step = 0;
    bit e_valid = 0, e_start = 0, e_err = 0, e_pass = 0;
    logic [SW-1:0] e_x = '0, e_y = '0;
    int pr, g;
    bit rdy;
    logic [BLK*SW-1:0] blk;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d (cycle %0d)", what, act, exp, cyc);
        end
    endtask

    // Advance the model with the inputs seen at this edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_q.delete(); m_act = 0; m_step = 0;
            e_valid = 0; e_start = 0; e_err = 0; e_pass = 0;
        end else begin
            rdy = (m_q.size() < NB);
            e_valid = m_act;
            e_start = m_act && (m_step == 0);
            e_pass  = (m_step >= NP);
            if (m_act) begin
                blk = m_q[0];
                pr = m_step % NP;
                g = pr / 2;
                if (pr % 2 == 0) begin
                    e_x = blk[(3*g)*SW +: SW];
                    e_y = blk[(3*g+1)*SW +: SW];
                end else begin
                    e_x = '0;
                    e_y = blk[(3*g+2)*SW +: SW];
                end
                if (m_step == 2*NP-1) begin
                    m_act = 0;
                    void'(m_q.pop_front());
                end else m_step++;
            end else if (m_q.size() > 0) begin
                m_act = 1; m_step = 0;
            end
            e_err = 0;
            if (in_valid && rdy) begin
                if (in_start) begin
                    e_err = (m_cnt != 0);
                    m_cur[0 +: SW] = in_sym;
                    m_cnt = 1;
                end else if (m_cnt > 0) begin
                    m_cur[m_cnt*SW +: SW] = in_sym;
                    m_cnt++;
                end
                if (m_cnt == BLK) begin
                    m_q.push_back(m_cur);
                    m_cnt = 0;
                end
            end
        end
    end

    // Compare every port against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            if (out_valid) ov_cnt++;
            if (blk_err) err_seen++;
            if (!in_ready && stall_ph) stall_seen = 1;
            chk(out_valid === e_valid, "R2 out_valid", out_valid, e_valid);
            chk(out_start === e_start, "R5 out_start", out_start, e_start);
            chk(in_ready === (m_q.size() < NB), "R6 in_ready", in_ready, m_q.size() < NB);
            chk(blk_err === e_err, "R7 blk_err", blk_err, e_err);
            if (e_valid) begin
                chk(out_x === e_x, stall_ph ? "R9 out_x" : (e_pass ? "R4 out_x" : "R3 out_x"), out_x, e_x);
                chk(out_y === e_y, stall_ph ? "R9 out_y" : (e_pass ? "R4 out_y" : "R3 out_y"), out_y, e_y);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 50000) begin
            errors++;
            $display("FAIL R2 watchdog actual %0d expected below 50000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Offer one symbol until taken; while stalled, offer a junk value instead.
    task automatic send(input logic [SW-1:0] s, input bit st);
        forever begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = st;
            if (in_ready) begin
                in_sym = s;
                @(posedge clk);
                break;
            end else in_sym = ~s;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_start = 1'b0;
    endtask

    task automatic send_block(input int base, input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            send(SW'(base * 7 + i * 3 + (i >> 2)), i == 0);
            if (gaps && (i % 5 == 4)) idle();
        end
    endtask

    task automatic drain();
        idle();
        while (m_q.size() != 0 || m_act) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 out_valid in reset", out_valid, 0);
        chk(out_start === 1'b0, "R1 out_start in reset", out_start, 0);
        chk(in_ready === 1'b1, "R1 in_ready in reset", in_ready, 1);
        chk(blk_err === 1'b0, "R1 blk_err in reset", blk_err, 0);
        rst_n = 1'b1;
        @(posedge clk);
        cmp_en = 1;

        // R2 R3 R4 R5: one block, continuous input
        send_block(1, BLK, 0);
        drain();
        chk(ov_cnt == 2*NP, "R2 pairs per replay", ov_cnt, 2*NP);

        // R3: block with gaps in valid
        send_block(2, BLK, 1);
        drain();

        // R6 R9: three blocks back to back force a stall
        stall_ph = 1;
        send_block(3, BLK, 0);
        send_block(4, BLK, 0);
        send_block(5, BLK, 0);
        drain();
        stall_ph = 0;
        chk(stall_seen == 1, "R6 stall observed", stall_seen, 1);

        // R7: truncated block followed by a full one
        err_seen = 0;
        send_block(6, 10, 0);
        send_block(7, BLK, 0);
        drain();
        chk(err_seen == 1, "R7 error pulses", err_seen, 1);

        // R8: stray symbols outside any block
        ov_cnt = 0;
        err_seen = 0;
        for (int i = 0; i < 6; i++) send(SW'(i + 9), 1'b0);
        idle();
        repeat (40) @(negedge clk);
        chk(ov_cnt == 0, "R8 no output from stray symbols", ov_cnt, 0);
        chk(err_seen == 0, "R8 no error from stray symbols", err_seen, 0);
        send_block(8, BLK, 0);
        drain();
        chk(ov_cnt == 2*NP, "R8 next block replays normally", ov_cnt, 2*NP);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule